// File: doc/BRIEF.md
# OLED Controller Byte Command Decoder

This block sits behind an I2C target front end that has already recovered whole bytes. Each received byte arrives with a one-cycle valid strobe, and a separate one-cycle pulse marks the end of a transaction. A small mode machine sorts each byte as a prefix, a command opcode or a pixel data byte.

Command opcodes update the display state. This state is the column pointer, the page pointer, the start line and four flags: mirror, all-on, inverse and display enable. Some opcodes carry one trailing argument, which the block swallows without using it.

Data bytes come out on a registered write port aimed at a framebuffer of 132 columns by 8 pages, one byte per location. The port address is column + page*132, and the column pointer advances after each write. A redraw flag tells the scanout logic that the framebuffer has changed. Scanout clears the flag with a pulse once it has redrawn.

Top module: `oled_byte_decoder`

## Requirements
- R1: Synchronous reset puts the mode in idle and clears column, page, start line, all four flags, the pending-skip state, redraw, fb_we and err_pulse.
- R2: In idle, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte leaves the mode in idle and raises err_pulse for one cycle, in the cycle after the byte.
- R3: In data mode a byte with column < 132 produces, in the next cycle, fb_we=1, fb_addr = column + page*132 and fb_wdata = the byte. The column increments by one in the same cycle.
- R4: In data mode a byte that arrives with column >= 132 is dropped. fb_we stays 0 and the column stays as it was.
- R5: A decoded command opcode returns the mode to idle, so a new 0x80 is needed before the next opcode. Data mode persists across any number of bytes.
- R6: Opcodes 0x00-0x0F replace column bits [3:0] with opcode bits [3:0]. Opcodes 0x10-0x20 replace column bits [7:4] with opcode bits [3:0], so 0x20 writes a zero high nibble.
- R7: Opcodes 0xB0-0xBF set the page to opcode bits [2:0].
- R8: The opcode pairs 0xA0/0xA1, 0xA4/0xA5, 0xA6/0xA7 and 0xAE/0xAF write opcode bit 0 into mirror, all_on, inverse and disp_en respectively.
- R9: Opcodes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB set a pending skip. The next byte received in command mode is then discarded, the skip clears and the mode stays in command, so the byte after that is decoded as an opcode without a new prefix.
- R10: Opcodes 0x40-0x7F set the start line to zero. Opcodes 0xC0-0xC8 and 0xE3 are accepted. None of these raise err_pulse or change column, page or flags.
- R11: Any other opcode raises err_pulse for one cycle, changes no column, page or flag, and returns the mode to idle.
- R12: A transaction-end pulse returns the mode to idle from command or data mode.
- R13: redraw is set by every framebuffer write and cleared by redraw_clr. When both occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | 8 | Received byte |
| xfer_end | input | 1 | Transaction-end pulse |
| redraw_clr | input | 1 | Redraw-done pulse from scanout |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 11 | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| column | output | 8 | Column pointer |
| page | output | 3 | Page pointer |
| start_line | output | 6 | Display start line |
| mirror | output | 1 | Mirror flag |
| all_on | output | 1 | All-pixels-on flag |
| inverse | output | 1 | Inverse video flag |
| disp_en | output | 1 | Display enable flag |
| redraw | output | 1 | Framebuffer changed flag |
| err_pulse | output | 1 | Unexpected byte or unknown opcode |

## Verification
The argument swallowed after a skip opcode is followed by a bare opcode, with no new prefix. A design that returned to idle after the skip would flag that opcode as an idle-mode error, and a design that decoded the argument would flip the inverse flag. Opcode 0x20 must clear the column's high nibble; a decoder that stopped the high-nibble range at 0x1F would report it as unknown. A data write at column 131 must land at the last address of the page, while the byte after it must be dropped; an off-by-one bound would either lose the last column or write past the page. A transaction end in command mode, and a redraw clear that coincides with a write, expose a missing idle return and a clear that wrongly beats the set.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;
  typedef enum logic [1:0] {M_IDLE = 2'd0, M_CMD = 2'd1, M_DATA = 2'd2} mode_e;

  typedef enum logic [2:0] {
    OP_BAD, OP_NOP, OP_COL_LO, OP_COL_HI, OP_START, OP_PAGE, OP_FLAG, OP_SKIP
  } op_e;

  // index into the flag vector
  typedef enum logic [1:0] {F_MIRROR = 2'd0, F_ALLON = 2'd1, F_INV = 2'd2, F_EN = 2'd3} flag_e;

  typedef struct packed {
    op_e   kind;
    flag_e flag;
    logic  val;
  } op_t;

  localparam logic [7:0] PFX_CMD  = 8'h80;
  localparam logic [7:0] PFX_DATA = 8'h40;
endpackage

// File: rtl/oled_cmd_decode.sv
module oled_cmd_decode
  import oled_dec_pkg::*;
(
  input  logic [7:0] opc,
  output op_t        op
);
  always_comb begin
    op.kind = OP_BAD;
    op.flag = F_MIRROR;
    op.val  = opc[0];
    if (opc[7:4] == 4'h0) begin
      op.kind = OP_COL_LO;
    end else if (opc >= 8'h10 && opc <= 8'h20) begin
      op.kind = OP_COL_HI;
    end else if (opc[7:6] == 2'b01) begin
      op.kind = OP_START;
    end else if (opc[7:4] == 4'hB) begin
      op.kind = OP_PAGE;
    end else if ((opc >= 8'hC0 && opc <= 8'hC8) || opc == 8'hE3) begin
      op.kind = OP_NOP;
    end else if (opc[7:4] == 4'hA) begin
      unique case (opc[3:1])
        3'd0: begin op.kind = OP_FLAG; op.flag = F_MIRROR; end
        3'd2: begin op.kind = OP_FLAG; op.flag = F_ALLON;  end
        3'd3: begin op.kind = OP_FLAG; op.flag = F_INV;    end
        3'd7: begin op.kind = OP_FLAG; op.flag = F_EN;     end
        3'd4: if (opc[0]) op.kind = OP_SKIP;  // 0xA9 stays unknown
              else        op.kind = OP_SKIP;  // 0xA8
        3'd6: if (opc[0]) op.kind = OP_SKIP;  // 0xAD
        default: op.kind = OP_BAD;
      endcase
      if (opc == 8'hA9) op.kind = OP_BAD;
    end else begin
      unique case (opc)
        8'h81, 8'hD3, 8'hD5, 8'hD8, 8'hD9, 8'hDA, 8'hDB: op.kind = OP_SKIP;
        default: op.kind = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/oled_fb_port.sv
module oled_fb_port #(
  parameter int COLS   = 132,
  parameter int PAGES  = 8,
  parameter int COL_W  = 8,
  parameter int PAGE_W = 3,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [COL_W-1:0]  col,
  input  logic [PAGE_W-1:0] pg,
  input  logic [7:0]        wdata,
  input  logic              redraw_clr,
  output logic              fb_we,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [7:0]        fb_wdata,
  output logic              redraw
);
  logic [ADDR_W-1:0] addr_next;

  assign addr_next = ADDR_W'(pg) * ADDR_W'(COLS) + ADDR_W'(col);

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
      redraw   <= 1'b0;
    end else begin
      fb_we <= wr_req;
      if (wr_req) begin
        fb_addr  <= addr_next;
        fb_wdata <= wdata;
      end
      if (wr_req)          redraw <= 1'b1;
      else if (redraw_clr) redraw <= 1'b0;
    end
  end
endmodule

// File: rtl/oled_byte_decoder.sv
module oled_byte_decoder
  import oled_dec_pkg::*;
#(
  parameter int COLS    = 132,
  parameter int PAGES   = 8,
  parameter int START_W = 6
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                byte_vld,
  input  logic [7:0]                          byte_in,
  input  logic                                xfer_end,
  input  logic                                redraw_clr,
  output logic                                fb_we,
  output logic [$clog2(COLS*PAGES)-1:0]       fb_addr,
  output logic [7:0]                          fb_wdata,
  output logic [7:0]                          column,
  output logic [$clog2(PAGES)-1:0]            page,
  output logic [START_W-1:0]                  start_line,
  output logic                                mirror,
  output logic                                all_on,
  output logic                                inverse,
  output logic                                disp_en,
  output logic                                redraw,
  output logic                                err_pulse
);
  localparam int COL_W  = 8;
  localparam int PAGE_W = $clog2(PAGES);
  localparam int ADDR_W = $clog2(COLS*PAGES);

  mode_e      mode_q;
  logic       skip_q;
  logic [3:0] flags_q;
  op_t        op;
  logic       wr_req;

  oled_cmd_decode u_dec (.opc(byte_in), .op(op));

  assign wr_req = byte_vld && (mode_q == M_DATA) && (column < COL_W'(COLS));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_IDLE;
      skip_q     <= 1'b0;
      column     <= '0;
      page       <= '0;
      start_line <= '0;
      flags_q    <= '0;
      err_pulse  <= 1'b0;
    end else begin
      err_pulse <= 1'b0;
      if (byte_vld) begin
        unique case (mode_q)
          M_IDLE: begin
            if (byte_in == PFX_CMD)       mode_q <= M_CMD;
            else if (byte_in == PFX_DATA) mode_q <= M_DATA;
            else                          err_pulse <= 1'b1;
          end
          M_DATA: begin
            if (wr_req) column <= column + 1'b1;
          end
          M_CMD: begin
            if (skip_q) begin
              skip_q <= 1'b0;   // argument consumed, stay in command
            end else begin
              mode_q <= M_IDLE;
              unique case (op.kind)
                OP_COL_LO: column[3:0] <= byte_in[3:0];
                OP_COL_HI: column[7:4] <= byte_in[3:0];
                OP_START:  start_line  <= '0;
                OP_PAGE:   page        <= byte_in[PAGE_W-1:0];
                OP_FLAG:   flags_q[op.flag] <= op.val;
                OP_SKIP:   skip_q      <= 1'b1;
                OP_NOP:    ;
                default:   err_pulse   <= 1'b1;
              endcase
            end
          end
          default: mode_q <= M_IDLE;
        endcase
      end
      if (xfer_end) mode_q <= M_IDLE;
    end
  end

  assign mirror  = flags_q[F_MIRROR];
  assign all_on  = flags_q[F_ALLON];
  assign inverse = flags_q[F_INV];
  assign disp_en = flags_q[F_EN];

  oled_fb_port #(
    .COLS(COLS), .PAGES(PAGES), .COL_W(COL_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)
  ) u_port (
    .clk(clk), .rst(rst), .wr_req(wr_req), .col(column), .pg(page),
    .wdata(byte_in), .redraw_clr(redraw_clr),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata), .redraw(redraw)
  );
endmodule

// File: rtl/oled_dec_checker.sv
module oled_dec_checker
  import oled_dec_pkg::*;
#(
  parameter int COLS = 132
) (
  input logic       clk,
  input logic       rst,
  input logic       byte_vld,
  input logic       xfer_end,
  input logic [1:0] mode,
  input logic       skip,
  input logic [7:0] column,
  input logic       fb_we,
  input logic       redraw,
  input logic       err
);
  p_end_idle_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> mode == M_IDLE);

  p_cmd_leaves_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_CMD && byte_vld && !skip) |=> mode == M_IDLE);

  p_data_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DATA && !xfer_end) |=> mode == M_DATA);

  p_skip_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == M_CMD && byte_vld && skip && !xfer_end) |=> (mode == M_CMD && !skip));

  p_skip_inert_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == M_CMD && byte_vld && skip) |=> ($stable(column) && !err));

  p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> $past(column) < 8'(COLS));

  p_write_marks_r13: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> redraw);

  p_err_source_r11: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(byte_vld));
endmodule

bind oled_byte_decoder oled_dec_checker #(.COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .byte_vld(byte_vld), .xfer_end(xfer_end),
  .mode(mode_q), .skip(skip_q), .column(column), .fb_we(fb_we),
  .redraw(redraw), .err(err_pulse)
);

// File: tb/test_oled_byte_decoder.sv
`timescale 1ns/1ps
module test_oled_byte_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        xfer_end = 1'b0;
  logic        redraw_clr = 1'b0;
  logic        fb_we;
  logic [10:0] fb_addr;
  logic [7:0]  fb_wdata;
  logic [7:0]  column;
  logic [2:0]  page;
  logic [5:0]  start_line;
  logic        mirror, all_on, inverse, disp_en, redraw, err_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  oled_byte_decoder i_oled_byte_decoder (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
    .xfer_end(xfer_end), .redraw_clr(redraw_clr), .fb_we(fb_we),
    .fb_addr(fb_addr), .fb_wdata(fb_wdata), .column(column), .page(page),
    .start_line(start_line), .mirror(mirror), .all_on(all_on),
    .inverse(inverse), .disp_en(disp_en), .redraw(redraw), .err_pulse(err_pulse)
  );

  // {req4, end1, byte8, we1, addr11, col8, page3, flags{en,allon,inv,mirror}4, err1}
  localparam int NV = 38;
  localparam logic [40:0] VEC [NV] = '{
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd0, 3'd0,4'b0000,1'b0}, // R2 enter command
    {4'd7, 1'b0,8'hB2,1'b0,11'd0,  8'd0, 3'd2,4'b0000,1'b0}, // R7 page 2
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd0, 3'd2,4'b0000,1'b0},
    {4'd6, 1'b0,8'h13,1'b0,11'd0,  8'd48,3'd2,4'b0000,1'b0}, // R6 high nibble
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd48,3'd2,4'b0000,1'b0},
    {4'd6, 1'b0,8'h05,1'b0,11'd0,  8'd53,3'd2,4'b0000,1'b0}, // R6 low nibble
    {4'd2, 1'b0,8'h40,1'b0,11'd0,  8'd53,3'd2,4'b0000,1'b0}, // R2 enter data
    {4'd3, 1'b0,8'hAA,1'b1,11'd317,8'd54,3'd2,4'b0000,1'b0}, // R3 write
    {4'd5, 1'b0,8'h55,1'b1,11'd318,8'd55,3'd2,4'b0000,1'b0}, // R5 data persists
    {4'd12,1'b1,8'h00,1'b0,11'd0,  8'd55,3'd2,4'b0000,1'b0}, // R12 end
    {4'd2, 1'b0,8'h55,1'b0,11'd0,  8'd55,3'd2,4'b0000,1'b1}, // R2 bad idle byte
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd55,3'd2,4'b0000,1'b0},
    {4'd8, 1'b0,8'hA7,1'b0,11'd0,  8'd55,3'd2,4'b0010,1'b0}, // R8 inverse on
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd55,3'd2,4'b0010,1'b0},
    {4'd8, 1'b0,8'hAF,1'b0,11'd0,  8'd55,3'd2,4'b1010,1'b0}, // R8 enable
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd55,3'd2,4'b1010,1'b0},
    {4'd8, 1'b0,8'hA1,1'b0,11'd0,  8'd55,3'd2,4'b1011,1'b0}, // R8 mirror
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd55,3'd2,4'b1011,1'b0},
    {4'd8, 1'b0,8'hA5,1'b0,11'd0,  8'd55,3'd2,4'b1111,1'b0}, // R8 all on
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd55,3'd2,4'b1111,1'b0},
    {4'd9, 1'b0,8'h81,1'b0,11'd0,  8'd55,3'd2,4'b1111,1'b0}, // R9 skip opcode
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd55,3'd2,4'b1111,1'b0},
    {4'd9, 1'b0,8'hA6,1'b0,11'd0,  8'd55,3'd2,4'b1111,1'b0}, // R9 argument swallowed
    {4'd9, 1'b0,8'hA0,1'b0,11'd0,  8'd55,3'd2,4'b1110,1'b0}, // R9 opcode without prefix
    {4'd5, 1'b0,8'hA0,1'b0,11'd0,  8'd55,3'd2,4'b1110,1'b1}, // R5 back in idle
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd55,3'd2,4'b1110,1'b0},
    {4'd11,1'b0,8'h99,1'b0,11'd0,  8'd55,3'd2,4'b1110,1'b1}, // R11 unknown
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd55,3'd2,4'b1110,1'b0},
    {4'd6, 1'b0,8'h20,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0}, // R6 0x20 edge
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0},
    {4'd10,1'b0,8'hE3,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0}, // R10 no-op
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0},
    {4'd10,1'b0,8'h45,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0}, // R10 start line
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0},
    {4'd10,1'b0,8'hC8,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0}, // R10 direction
    {4'd2, 1'b0,8'h80,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0},
    {4'd12,1'b1,8'h00,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b0}, // R12 end in command
    {4'd12,1'b0,8'hA4,1'b0,11'd0,  8'd7, 3'd2,4'b1110,1'b1}  // R12 idle again
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic e, input logic [7:0] b, input logic clr);
    @(negedge clk);
    byte_vld = !e; xfer_end = e; byte_in = b; redraw_clr = clr;
    @(negedge clk);
    byte_vld = 1'b0; xfer_end = 1'b0; redraw_clr = 1'b0;
  endtask

  task automatic check_reset();
    check(column == 0 && page == 0 && start_line == 0, "R1", "pointers", int'(column), 0);
    check({disp_en, all_on, inverse, mirror} == 4'b0, "R1", "flags",
          int'({disp_en, all_on, inverse, mirror}), 0);
    check(!fb_we && !redraw && !err_pulse, "R1", "we/redraw/err",
          int'({fb_we, redraw, err_pulse}), 0);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset();
    // 0x41 after reset must be an idle error: mode reset to idle (R1)
    drive(1'b0, 8'h41, 1'b0);
    check(err_pulse == 1'b1, "R1", "idle after reset", int'(err_pulse), 1);

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      string rq;
      v = VEC[i];
      drive(v[36], v[35:28], 1'b0);
      rq = $sformatf("R%0d", v[40:37]);
      check(fb_we == v[27], rq, $sformatf("vec %0d fb_we", i), int'(fb_we), int'(v[27]));
      if (v[27]) begin
        check(fb_addr == v[26:16], rq, $sformatf("vec %0d addr", i), int'(fb_addr), int'(v[26:16]));
        check(fb_wdata == v[35:28], rq, $sformatf("vec %0d wdata", i), int'(fb_wdata), int'(v[35:28]));
      end
      check(column == v[15:8], rq, $sformatf("vec %0d column", i), int'(column), int'(v[15:8]));
      check(page == v[7:5], rq, $sformatf("vec %0d page", i), int'(page), int'(v[7:5]));
      check({disp_en, all_on, inverse, mirror} == v[4:1], rq, $sformatf("vec %0d flags", i),
            int'({disp_en, all_on, inverse, mirror}), int'(v[4:1]));
      check(err_pulse == v[0], rq, $sformatf("vec %0d err", i), int'(err_pulse), int'(v[0]));
    end
    check(start_line == 0, "R10", "start line", int'(start_line), 0);

    // R4: last column written, next byte dropped (page 2)
    drive(1'b0, 8'h80, 1'b0); drive(1'b0, 8'h18, 1'b0);
    drive(1'b0, 8'h80, 1'b0); drive(1'b0, 8'h03, 1'b0);
    check(column == 131, "R6", "column 131", int'(column), 131);
    drive(1'b0, 8'h40, 1'b0);
    drive(1'b0, 8'h11, 1'b0);
    check(fb_we && fb_addr == 11'd395, "R4", "last column write", int'(fb_addr), 395);
    check(column == 132, "R4", "column past end", int'(column), 132);
    drive(1'b0, 8'h22, 1'b0);
    check(!fb_we, "R4", "dropped write", int'(fb_we), 0);
    check(column == 132, "R4", "column held", int'(column), 132);
    drive(1'b1, 8'h00, 1'b0);

    // R13: redraw set, cleared, set wins over clear
    check(redraw == 1'b1, "R13", "redraw set", int'(redraw), 1);
    drive(1'b0, 8'h55, 1'b1);  // idle byte (error) with clear pulse
    check(redraw == 1'b0, "R13", "redraw cleared", int'(redraw), 0);
    drive(1'b0, 8'h80, 1'b0); drive(1'b0, 8'h10, 1'b0);
    drive(1'b0, 8'h80, 1'b0); drive(1'b0, 8'h00, 1'b0);
    drive(1'b0, 8'h40, 1'b0);
    drive(1'b0, 8'h77, 1'b1);
    check(fb_we && fb_addr == 11'd264, "R3", "write at column 0", int'(fb_addr), 264);
    check(redraw == 1'b1, "R13", "set beats clear", int'(redraw), 1);

    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_reset();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule